// File: doc/BRIEF.md
# Vectored Trap and Interrupt Dispatcher

This unit turns three classes of control-transfer request into a single dispatch toward the core. The classes are synchronous faults raised by the core, software traps that carry an 8-bit vector, and sixteen level-sensitive device lines. Each request resolves to a vector in the range 0 to 255. Vectors 0 to 31 are reserved for processor faults. Device line k maps to vector 32+k. The remaining vectors serve software traps, for example 0x80 for system calls.

The vector indexes an on-chip table of 256 descriptors, which is filled through a simple write port. Each descriptor gives a code selector, a handler address, a target privilege ring, a valid bit and a gate kind. The dispatch output is held until the core acknowledges it. It carries the handler address, the selector, the target ring and a flag that tells the core whether to move onto the kernel stack. When that flag is set, the kernel stack selector and pointer come with it.

The unit owns the device-enable flag and a per-line in-service mask. It also keeps a small stack of saved context, which a return strobe unwinds.

Top module: `trap_dispatch_unit`

## Requirements
- R1: A dispatch raises `dispValid` one cycle after the request is sampled. The vector, handler address, selector and ring come from the descriptor most recently written at that index. `dispValid` and the payload hold unchanged until a cycle with `dispAck` high. A request is only sampled while `dispValid` is low.
- R2: When requests coincide, the priority is fault, then software trap, then device line. Among eligible device lines, the lowest line number wins, and line k dispatches vector 32+k.
- R3: A fault on `excVec` (0 to 31) is dispatched whether the enable flag is set or clear.
- R4: A device line is eligible only while the enable flag is 1. The flag appears at bit 9 of `flagsWord`, and every other bit of `flagsWord` reads 0. `stiCmd` sets the flag and `cliCmd` clears it, with effect from the next cycle. If both are high in the same cycle, the clear wins.
- R5: A descriptor with `tblGate`=1 is an interrupt gate, and dispatching through it clears the flag. A descriptor with `tblGate`=0 is a trap gate and leaves the flag unchanged.
- R6: If the selected vector's descriptor has its valid bit at 0, the unit dispatches vector 13 instead, using the payload of descriptor 13.
- R7: A software trap whose current ring is numerically greater than the descriptor's ring dispatches vector 13. A descriptor with ring 3 is reachable from ring 3.
- R8: A device line that is in service is not dispatched again. A different eligible line can still nest on top of it. Each dispatched line sets its own bit in `inService`.
- R9: `dispStackSwitch` is 1 exactly when the target ring differs from the current ring. When it is 1, `dispStackSel`/`dispStackPtr` carry `kernSs`/`kernSp`; otherwise both are 0. After the dispatch, `curRing` equals the target ring.
- R10: `iretStrobe` pops the newest saved context. It restores the flag and the ring, and it clears the in-service bit of the line that context belongs to.
- R11: A cycle with `iretStrobe` high issues no dispatch. A request still pending is dispatched in the next cycle. `cliCmd`, `stiCmd` and `ringLoad` have no effect in a cycle that issues a dispatch or has `iretStrobe` high.
- R12: A dispatch made while the stack already holds DEPTH (4) contexts sets `nestOverflow`, which stays set until reset. `iretStrobe` with an empty stack changes nothing.
- R13: After reset, `dispValid`, `flagsWord`, `inService`, `curRing` and `nestOverflow` are all 0, and every descriptor is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excReq | input | 1 | Fault request strobe |
| excVec | input | 5 | Fault vector |
| swiReq | input | 1 | Software trap strobe |
| swiVec | input | 8 | Software trap vector |
| irqLines | input | 16 | Device request lines, level sensitive |
| cliCmd | input | 1 | Clear enable flag |
| stiCmd | input | 1 | Set enable flag |
| ringLoad | input | 1 | Load current ring from `ringVal` |
| ringVal | input | 2 | Ring to load |
| iretStrobe | input | 1 | Return from handler |
| dispAck | input | 1 | Core accepts the dispatch |
| tblWe | input | 1 | Descriptor write enable |
| tblIdx | input | 8 | Descriptor index |
| tblSel | input | 16 | Code selector to write |
| tblOff | input | 32 | Handler address to write |
| tblRing | input | 2 | Target ring to write |
| tblPresent | input | 1 | Valid bit to write |
| tblGate | input | 1 | 1 interrupt gate, 0 trap gate |
| kernSs | input | 16 | Kernel stack selector |
| kernSp | input | 32 | Kernel stack pointer |
| dispValid | output | 1 | Dispatch pending |
| dispVec | output | 8 | Dispatched vector |
| dispOff | output | 32 | Handler address |
| dispSel | output | 16 | Code selector |
| dispRing | output | 2 | Target ring |
| dispStackSwitch | output | 1 | Move to kernel stack |
| dispStackSel | output | 16 | Stack selector when switching |
| dispStackPtr | output | 32 | Stack pointer when switching |
| flagsWord | output | 32 | Flags, enable at bit 9 |
| inService | output | 16 | Per-line in-service mask |
| curRing | output | 2 | Current ring |
| nestOverflow | output | 1 | Sticky context-stack overflow |

## Verification
A return strobe can coincide with a pending request. It can also coincide with a flag command. The bench provokes this by raising `iretStrobe`, `cliCmd` and a device line on the same edge while a fault context sits on the stack. In that cycle it expects no dispatch, the ring popped back to 0 and the flag restored to 1 despite the clear command. One cycle later it expects the device vector to be dispatched, which shows the request was held rather than lost.

// File: rtl/tdu_pkg.sv
`timescale 1ns/1ps
package tdu_pkg;
  localparam int VEC_W    = 8;
  localparam int VEC_N    = 1 << VEC_W;
  localparam int SEL_W    = 16;
  localparam int OFF_W    = 32;
  localparam int RING_W   = 2;
  localparam int IRQ_N    = 16;
  localparam int LINE_W   = $clog2(IRQ_N);
  localparam int EXC_W    = 5;
  localparam int IRQ_BASE = 32;
  localparam int GP_VEC   = 13;
  localparam int FLAG_W   = 32;
  localparam int IF_BIT   = 9;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic [RING_W-1:0] ring;
    logic              present;
    logic              intGate;
  } desc_t;

  typedef struct packed {
    logic              ie;
    logic [RING_W-1:0] ring;
    logic              irq;
    logic [LINE_W-1:0] line;
  } frame_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              issue;
    logic              useGp;
    logic              irqHit;
    logic [LINE_W-1:0] irqLine;
    logic              pop;
    logic              ifClr;
    logic              ifSet;
    logic              ringLd;
  } ctl_t;
endpackage

// File: rtl/tdu_control.sv
`timescale 1ns/1ps
module tdu_control
  import tdu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [EXC_W-1:0]  excVec,
  input  logic              swiReq,
  input  logic [VEC_W-1:0]  swiVec,
  input  logic [IRQ_N-1:0]  irqLines,
  input  logic              cliCmd,
  input  logic              stiCmd,
  input  logic              ringLoad,
  input  logic              iretStrobe,
  input  logic              dispAck,
  input  logic              ifFlag,
  input  logic [IRQ_N-1:0]  inService,
  input  logic [RING_W-1:0] curRing,
  input  logic              reqPresent,
  input  logic [RING_W-1:0] reqRing,
  output logic [VEC_W-1:0]  reqVec,
  output ctl_t              ctl,
  output logic              dispValid
);
  logic [IRQ_N-1:0]  eligible;
  logic              anyIrq;
  logic [LINE_W-1:0] pick;
  logic              quiet;

  always_comb begin
    eligible = irqLines & ~inService & {IRQ_N{ifFlag}};
    anyIrq   = |eligible;
    pick     = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (eligible[i]) pick = LINE_W'(i);
    end
  end

  always_comb begin
    if (excReq)      reqVec = VEC_W'(excVec);
    else if (swiReq) reqVec = swiVec;
    else             reqVec = VEC_W'(IRQ_BASE) + VEC_W'(pick);
  end

  always_comb begin
    ctl         = '0;
    ctl.pop     = iretStrobe;
    ctl.issue   = !dispValid && !iretStrobe && (excReq || swiReq || anyIrq);
    ctl.irqHit  = ctl.issue && !excReq && !swiReq;
    ctl.irqLine = pick;
    ctl.useGp   = !reqPresent || (swiReq && !excReq && (curRing > reqRing));
    quiet       = !ctl.issue && !iretStrobe;
    ctl.ifClr   = quiet && cliCmd;
    ctl.ifSet   = quiet && stiCmd;
    ctl.ringLd  = quiet && ringLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dispValid <= 1'b0;
    else if (ctl.issue) dispValid <= 1'b1;
    else if (dispAck)   dispValid <= 1'b0;
  end
endmodule

// File: rtl/tdu_datapath.sv
`timescale 1ns/1ps
module tdu_datapath
  import tdu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [VEC_W-1:0]  reqVec,
  input  logic              tblWe,
  input  logic [VEC_W-1:0]  tblIdx,
  input  desc_t             tblData,
  input  logic [RING_W-1:0] ringVal,
  input  logic [SEL_W-1:0]  kernSs,
  input  logic [OFF_W-1:0]  kernSp,
  output logic              reqPresent,
  output logic [RING_W-1:0] reqRing,
  output logic              ifFlag,
  output logic [IRQ_N-1:0]  inService,
  output logic [RING_W-1:0] curRing,
  output logic              nestOverflow,
  output logic [VEC_W-1:0]  dispVec,
  output logic [OFF_W-1:0]  dispOff,
  output logic [SEL_W-1:0]  dispSel,
  output logic [RING_W-1:0] dispRing,
  output logic              dispStackSwitch,
  output logic [SEL_W-1:0]  dispStackSel,
  output logic [OFF_W-1:0]  dispStackPtr
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  desc_t             tbl [VEC_N];
  frame_t            stk [DEPTH];
  logic [SP_W-1:0]   sp;
  desc_t             reqDesc, useDesc;
  logic [VEC_W-1:0]  useVec;
  logic              switchNeed, stackFull, canPop;
  frame_t            pushFrame, topFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < VEC_N; i++) tbl[i] <= '0;
    end else if (tblWe) begin
      tbl[tblIdx] <= tblData;
    end
  end

  always_comb begin
    reqDesc    = tbl[reqVec];
    reqPresent = reqDesc.present;
    reqRing    = reqDesc.ring;
    useDesc    = ctl.useGp ? tbl[GP_VEC] : reqDesc;
    useVec     = ctl.useGp ? VEC_W'(GP_VEC) : reqVec;
    switchNeed = useDesc.ring != curRing;
    stackFull  = sp == SP_W'(DEPTH);
    canPop     = ctl.pop && (sp != '0);
    topFrame   = stk[IDX_W'(sp - 1'b1)];
    pushFrame  = '{ie: ifFlag, ring: curRing, irq: ctl.irqHit, line: ctl.irqLine};
  end

  always_ff @(posedge clk) begin
    if (ctl.issue && !stackFull) stk[IDX_W'(sp)] <= pushFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifFlag          <= 1'b0;
      curRing         <= '0;
      sp              <= '0;
      nestOverflow    <= 1'b0;
      dispVec         <= '0;
      dispOff         <= '0;
      dispSel         <= '0;
      dispRing        <= '0;
      dispStackSwitch <= 1'b0;
      dispStackSel    <= '0;
      dispStackPtr    <= '0;
    end else if (ctl.issue) begin
      dispVec         <= useVec;
      dispOff         <= useDesc.off;
      dispSel         <= useDesc.sel;
      dispRing        <= useDesc.ring;
      dispStackSwitch <= switchNeed;
      dispStackSel    <= switchNeed ? kernSs : '0;
      dispStackPtr    <= switchNeed ? kernSp : '0;
      curRing         <= useDesc.ring;
      if (useDesc.intGate) ifFlag <= 1'b0;
      if (stackFull) nestOverflow <= 1'b1;
      else           sp <= sp + 1'b1;
    end else if (canPop) begin
      ifFlag  <= topFrame.ie;
      curRing <= topFrame.ring;
      sp      <= sp - 1'b1;
    end else begin
      if (ctl.ifClr)      ifFlag <= 1'b0;
      else if (ctl.ifSet) ifFlag <= 1'b1;
      if (ctl.ringLd) curRing <= ringVal;
    end
  end

  for (genvar g = 0; g < IRQ_N; g++) begin : g_svc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        inService[g] <= 1'b0;
      else if (ctl.issue && ctl.irqHit && ctl.irqLine == LINE_W'(g))
        inService[g] <= 1'b1;
      else if (canPop && topFrame.irq && topFrame.line == LINE_W'(g))
        inService[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_dispatch_unit.sv
`timescale 1ns/1ps
module trap_dispatch_unit
  import tdu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [EXC_W-1:0]  excVec,
  input  logic              swiReq,
  input  logic [VEC_W-1:0]  swiVec,
  input  logic [IRQ_N-1:0]  irqLines,
  input  logic              cliCmd,
  input  logic              stiCmd,
  input  logic              ringLoad,
  input  logic [RING_W-1:0] ringVal,
  input  logic              iretStrobe,
  input  logic              dispAck,
  input  logic              tblWe,
  input  logic [VEC_W-1:0]  tblIdx,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [OFF_W-1:0]  tblOff,
  input  logic [RING_W-1:0] tblRing,
  input  logic              tblPresent,
  input  logic              tblGate,
  input  logic [SEL_W-1:0]  kernSs,
  input  logic [OFF_W-1:0]  kernSp,
  output logic              dispValid,
  output logic [VEC_W-1:0]  dispVec,
  output logic [OFF_W-1:0]  dispOff,
  output logic [SEL_W-1:0]  dispSel,
  output logic [RING_W-1:0] dispRing,
  output logic              dispStackSwitch,
  output logic [SEL_W-1:0]  dispStackSel,
  output logic [OFF_W-1:0]  dispStackPtr,
  output logic [FLAG_W-1:0] flagsWord,
  output logic [IRQ_N-1:0]  inService,
  output logic [RING_W-1:0] curRing,
  output logic              nestOverflow
);
  ctl_t              ctl;
  logic [VEC_W-1:0]  reqVec;
  logic              reqPresent, ifFlag;
  logic [RING_W-1:0] reqRing;
  desc_t             tblData;

  assign tblData   = '{sel: tblSel, off: tblOff, ring: tblRing,
                       present: tblPresent, intGate: tblGate};
  assign flagsWord = FLAG_W'(ifFlag) << IF_BIT;

  tdu_control u_ctl (
    .clk, .rstN, .excReq, .excVec, .swiReq, .swiVec, .irqLines,
    .cliCmd, .stiCmd, .ringLoad, .iretStrobe, .dispAck,
    .ifFlag, .inService, .curRing, .reqPresent, .reqRing,
    .reqVec, .ctl, .dispValid
  );

  tdu_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .ctl, .reqVec, .tblWe, .tblIdx, .tblData, .ringVal,
    .kernSs, .kernSp, .reqPresent, .reqRing, .ifFlag, .inService,
    .curRing, .nestOverflow, .dispVec, .dispOff, .dispSel, .dispRing,
    .dispStackSwitch, .dispStackSel, .dispStackPtr
  );
endmodule

// File: rtl/tdu_checker.sv
`timescale 1ns/1ps
module tdu_checker
  import tdu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dispValid,
  input logic              dispAck,
  input logic [VEC_W-1:0]  dispVec,
  input logic [OFF_W-1:0]  dispOff,
  input logic [RING_W-1:0] dispRing,
  input logic              dispStackSwitch,
  input logic              ifNow,
  input logic [IRQ_N-1:0]  inService,
  input logic [RING_W-1:0] curRing,
  input logic              iretStrobe,
  input logic              nestOverflow
);
  // R1
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !dispAck |=> dispValid && $stable(dispVec) && $stable(dispOff));

  // R4
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(inService & ~$past(inService))) |-> $past(ifNow));

  // R8
  single_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inService & ~$past(inService)));

  // R9
  stack_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispValid) |-> dispStackSwitch == (dispRing != $past(curRing)));

  // R9
  ring_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispValid) |-> curRing == dispRing);

  // R11
  return_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    iretStrobe |=> !$rose(dispValid));

  // R12
  no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(nestOverflow) |-> nestOverflow);
endmodule

bind trap_dispatch_unit tdu_checker u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispAck(dispAck),
  .dispVec(dispVec), .dispOff(dispOff), .dispRing(dispRing),
  .dispStackSwitch(dispStackSwitch), .ifNow(flagsWord[tdu_pkg::IF_BIT]),
  .inService(inService), .curRing(curRing), .iretStrobe(iretStrobe),
  .nestOverflow(nestOverflow)
);

// File: tb/trap_dispatch_unit_test.sv
`timescale 1ns/1ps
module trap_dispatch_unit_test;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        excReq = 0, swiReq = 0, cliCmd = 0, stiCmd = 0, ringLoad = 0;
  logic        iretStrobe = 0, dispAck = 0, tblWe = 0, tblPresent = 0, tblGate = 0;
  logic [4:0]  excVec = '0;
  logic [7:0]  swiVec = '0, tblIdx = '0;
  logic [15:0] irqLines = '0, tblSel = '0;
  logic [1:0]  ringVal = '0, tblRing = '0;
  logic [31:0] tblOff = '0;
  logic [15:0] kernSs = 16'h0018;
  logic [31:0] kernSp = 32'h0000_FFF0;
  logic        dispValid, dispStackSwitch, nestOverflow;
  logic [7:0]  dispVec;
  logic [31:0] dispOff, dispStackPtr, flagsWord;
  logic [15:0] dispSel, dispStackSel, inService;
  logic [1:0]  dispRing, curRing;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  trap_dispatch_unit uut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excVec(excVec), .swiReq(swiReq),
    .swiVec(swiVec), .irqLines(irqLines), .cliCmd(cliCmd), .stiCmd(stiCmd),
    .ringLoad(ringLoad), .ringVal(ringVal), .iretStrobe(iretStrobe),
    .dispAck(dispAck), .tblWe(tblWe), .tblIdx(tblIdx), .tblSel(tblSel),
    .tblOff(tblOff), .tblRing(tblRing), .tblPresent(tblPresent),
    .tblGate(tblGate), .kernSs(kernSs), .kernSp(kernSp),
    .dispValid(dispValid), .dispVec(dispVec), .dispOff(dispOff),
    .dispSel(dispSel), .dispRing(dispRing), .dispStackSwitch(dispStackSwitch),
    .dispStackSel(dispStackSel), .dispStackPtr(dispStackPtr),
    .flagsWord(flagsWord), .inService(inService), .curRing(curRing),
    .nestOverflow(nestOverflow)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setDesc(int idx, logic [15:0] sel, logic [31:0] off,
                         logic [1:0] ring, logic pres, logic gate);
    tblWe = 1; tblIdx = 8'(idx); tblSel = sel; tblOff = off;
    tblRing = ring; tblPresent = pres; tblGate = gate;
    step(); tblWe = 0;
  endtask

  task automatic ack(); dispAck = 1; step(); dispAck = 0; endtask
  task automatic iret(); iretStrobe = 1; step(); iretStrobe = 0; endtask
  task automatic exc(int v); excReq = 1; excVec = 5'(v); step(); excReq = 0; endtask
  task automatic swi(int v); swiReq = 1; swiVec = 8'(v); step(); swiReq = 0; endtask
  task automatic sti(); stiCmd = 1; step(); stiCmd = 0; endtask
  task automatic cli(); cliCmd = 1; step(); cliCmd = 0; endtask

  task automatic testReset();
    chk("R13 dispValid", dispValid, 0);
    chk("R13 flagsWord", flagsWord, 0);
    chk("R13 inService", inService, 0);
    chk("R13 curRing", curRing, 0);
    chk("R13 nestOverflow", nestOverflow, 0);
    exc(14);  // nothing loaded yet: invalid descriptor gives vector 13
    chk("R13 empty table", dispVec, 13);
    ack(); iret();
  endtask

  task automatic loadTable();
    setDesc(3,    16'h0008, 32'h0000_3000, 2'd3, 1, 0);
    setDesc(13,   16'h0008, 32'h0000_D000, 2'd0, 1, 0);
    setDesc(14,   16'h0008, 32'h0000_E000, 2'd0, 1, 0);
    setDesc(8'h80, 16'h0009, 32'h0000_8000, 2'd3, 1, 0);
    setDesc(8'h90, 16'h0008, 32'h0000_9000, 2'd0, 1, 0);
    for (int k = 0; k < 16; k++)
      setDesc(32 + k, 16'h0010, 32'h2000_0000 + k, 2'd0, k != 8, 1);
  endtask

  task automatic testFault();
    exc(14);
    chk("R1 valid", dispValid, 1);
    chk("R3 vector with flag clear", dispVec, 14);
    chk("R1 address", dispOff, 32'h0000_E000);
    chk("R1 selector", dispSel, 16'h0008);
    chk("R9 same ring no switch", dispStackSwitch, 0);
    chk("R9 no stack ptr", dispStackPtr, 0);
    step();
    chk("R1 held without ack", dispValid, 1);
    ack();
    chk("R1 cleared by ack", dispValid, 0);
    iret();
    chk("R10 ring back", curRing, 0);
  endtask

  task automatic testSoftware();
    ringLoad = 1; ringVal = 3; step(); ringLoad = 0;
    chk("R7 ring loaded", curRing, 3);
    swi(8'h80);
    chk("R7 user reachable", dispVec, 8'h80);
    chk("R7 ring", dispRing, 3);
    chk("R9 no switch", dispStackSwitch, 0);
    ack(); iret();
    swi(8'h90);
    chk("R7 privilege to 13", dispVec, 13);
    chk("R9 switch", dispStackSwitch, 1);
    chk("R9 stack sel", dispStackSel, 16'h0018);
    chk("R9 stack ptr", dispStackPtr, 32'h0000_FFF0);
    chk("R9 cur ring", curRing, 0);
    ack(); iret();
    chk("R10 ring restored", curRing, 3);
    swi(8'h55);
    chk("R6 invalid to 13", dispVec, 13);
    chk("R6 address of 13", dispOff, 32'h0000_D000);
    ack(); iret();
    ringLoad = 1; ringVal = 0; step(); ringLoad = 0;
  endtask

  task automatic testIrq();
    irqLines = 16'h0006; step(); step();
    chk("R4 masked", dispValid, 0);
    sti();
    chk("R4 flag bit 9", flagsWord, 32'h200);
    chk("R4 not yet", dispValid, 0);
    step();
    chk("R2 lowest line", dispVec, 33);
    chk("R5 gate clears", flagsWord, 0);
    chk("R8 line1 set", inService, 16'h0002);
    ack(); sti(); step();
    chk("R8 other line nests", dispVec, 34);
    chk("R8 two set", inService, 16'h0006);
    ack(); sti(); step();
    chk("R8 no retrigger", dispValid, 0);
    irqLines = 0;
    iret();
    chk("R10 svc cleared", inService, 16'h0002);
    chk("R10 flag restored", flagsWord, 32'h200);
    iret();
    chk("R10 svc empty", inService, 0);
    cli();
    chk("R4 cli", flagsWord, 0);
  endtask

  task automatic testPriority();
    sti();
    excReq = 1; excVec = 14; swiReq = 1; swiVec = 8'h80; irqLines = 16'h0018;
    step(); excReq = 0; swiReq = 0;
    chk("R2 fault first", dispVec, 14);
    chk("R5 trap gate keeps", flagsWord, 32'h200);
    ack();
    chk("R1 ack", dispValid, 0);
    step();
    chk("R2 line 3 of 3,4", dispVec, 35);
    chk("R2 svc", inService, 16'h0008);
    ack(); irqLines = 0;
    iret(); iret();
    chk("R10 unwound", inService, 0);
    swiReq = 1; swiVec = 8'h80; irqLines = 16'h0001;
    step(); swiReq = 0;
    chk("R2 trap over line", dispVec, 8'h80);
    ack(); irqLines = 0;
    iret();
  endtask

  task automatic testAbsent();
    irqLines = 16'h0100; step();
    chk("R6 invalid line to 13", dispVec, 13);
    chk("R8 line8 svc", inService, 16'h0100);
    irqLines = 0; ack(); iret();
    chk("R10 line8 cleared", inService, 0);
  endtask

  task automatic testCollide();
    exc(3);
    chk("R9 fault to ring 3", dispRing, 3);
    chk("R9 switch up", dispStackSwitch, 1);
    chk("R9 cur ring 3", curRing, 3);
    ack();
    irqLines = 16'h0001; iretStrobe = 1; cliCmd = 1;
    step(); iretStrobe = 0; cliCmd = 0;
    chk("R11 no dispatch", dispValid, 0);
    chk("R11 popped ring", curRing, 0);
    chk("R11 cli ignored", flagsWord, 32'h200);
    step();
    chk("R11 held request", dispVec, 32);
    chk("R11 valid", dispValid, 1);
    irqLines = 0; ack(); iret();
  endtask

  task automatic testOverflow();
    iret();
    chk("R12 empty pop ring", curRing, 0);
    chk("R12 empty pop flag", flagsWord, 32'h200);
    for (int n = 1; n <= 5; n++) begin
      exc(14); ack();
      if (n == 4) chk("R12 full no flag", nestOverflow, 0);
    end
    chk("R12 overflow", nestOverflow, 1);
    for (int n = 0; n < 4; n++) iret();
    chk("R12 sticky", nestOverflow, 1);
    chk("R12 ring", curRing, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all R act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    testReset();
    loadTable();
    testFault();
    testSoftware();
    testIrq();
    testPriority();
    testAbsent();
    testCollide();
    testOverflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule